// File: doc/BRIEF.md
# Stereo Serial Audio Port

This block is the digital edge of a stereo converter pair. It runs as a slave: an external bit clock and an external word clock pace all transfers. Both clocks, and the serial input, are sampled by a faster system clock. On the receive side, 16-bit words for the two playback channels arrive on the serial input. Each is aligned so that it ends at the word-clock edge. Every finished word is handed to parallel outputs with a one-cycle strobe. On the transmit side, two 16-bit capture samples are shifted out on the serial output. Each starts at the word-clock edge that opens its channel.

The frame length is not configured. A word-clock period may hold 32, 48 or 64 bit clocks, and the port frames correctly on each. A power-down input forces the serial output to zero. The receive path keeps running while it is set.

Top module: `serial_audio_port`

## Requirements
- R1: Words are 16 bits, most significant bit first, and the serial input is sampled on bit-clock rising edges. The received word for a half-period is the last 16 bits sampled before the word-clock transition that closes it, so any earlier bits in that half are discarded.
- R2: When the word clock falls (end of the left half, word clock high = left), the left word appears on `rx_left` together with a single-cycle `rx_left_vld`. `rx_left` is otherwise held.
- R3: When the word clock rises (end of the right half), the right word appears on `rx_right` together with a single-cycle `rx_right_vld`. `rx_right` is otherwise held.
- R4: Frames of 32, 48 and 64 bit clocks per word-clock period are handled with no configuration input.
- R5: After each word-clock transition, the serial output carries the most significant bit of `tx_left` (word clock high) or `tx_right` (word clock low) before the first following bit-clock rising edge. Each later bit is presented after a bit-clock falling edge.
- R6: Once the 16 bits of a half-period have been sent, the serial output is low for the rest of that half.
- R7: While `adc_pd` is high, `sdout` is 0 from the next system clock on. The receive path is unaffected.
- R8: After reset, all outputs are 0, and no receive strobe is raised before the first word-clock transition.
- R9: The two receive strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| bclk | input | 1 | External bit clock |
| wclk | input | 1 | External word clock, high = left channel |
| sdin | input | 1 | Serial receive data, right-aligned |
| adc_pd | input | 1 | Capture power-down, forces `sdout` low |
| tx_left | input | 16 | Left capture sample to send |
| tx_right | input | 16 | Right capture sample to send |
| sdout | output | 1 | Serial transmit data, left-aligned |
| rx_left | output | 16 | Last received left word |
| rx_right | output | 16 | Last received right word |
| rx_left_vld | output | 1 | One-cycle strobe for a new `rx_left` |
| rx_right_vld | output | 1 | One-cycle strobe for a new `rx_right` |

## Verification
The bench builds the port with 16-bit words and a two-stage input synchronizer, and runs the bit clock at sixteen system clocks per period. This leaves room to observe every synchronizer and register delay inside a single bit slot. The bench sweeps all three frame lengths, so receive words of 16, 24 and 32 slots per half show the discarding of leading bits. On transmit, the same sweep checks every bit slot, including the zero padding. A warm-up stretch before the first word-clock edge, a power-down frame and extreme words (0x0000, 0xFFFF, 0x8000, 0x0001) reach the reset, gating and alignment corners.

// File: rtl/audio_port_pkg.sv
package audio_port_pkg;

    localparam int SAMPLE_W = 16;

    typedef enum logic {
        CH_RIGHT = 1'b0,
        CH_LEFT  = 1'b1
    } chan_e;

    typedef struct packed {
        logic rise;    // bit clock rising edge seen this cycle
        logic fall;    // bit clock falling edge seen this cycle
        logic ws;      // synchronized word clock level
        logic ws_chg;  // word clock changed this cycle
        logic sd;      // synchronized serial input
    } link_ev_t;

    function automatic chan_e chan_of(input logic ws);
        return ws ? CH_LEFT : CH_RIGHT;
    endfunction

endpackage

// File: rtl/ap_edge_detect.sv
module ap_edge_detect
    import audio_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     bclk,
    input  logic     wclk,
    input  logic     sdin,
    output link_ev_t ev
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] b_s, w_s, d_s;
    logic b_d, w_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            b_s <= '0;
            w_s <= '0;
            d_s <= '0;
            b_d <= 1'b0;
            w_d <= 1'b0;
        end else begin
            b_s[0] <= bclk;
            w_s[0] <= wclk;
            d_s[0] <= sdin;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                b_s[i] <= b_s[i-1];
                w_s[i] <= w_s[i-1];
                d_s[i] <= d_s[i-1];
            end
            b_d <= b_s[LAST];
            w_d <= w_s[LAST];
        end
    end

    always_comb begin
        ev.rise   = b_s[LAST] & ~b_d;
        ev.fall   = ~b_s[LAST] & b_d;
        ev.ws     = w_s[LAST];
        ev.ws_chg = w_s[LAST] ^ w_d;
        ev.sd     = d_s[LAST];
    end

endmodule

// File: rtl/ap_rx_deser.sv
module ap_rx_deser
    import audio_port_pkg::*;
#(
    parameter int WORD_W = SAMPLE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rise,
    input  logic              ws,
    input  logic              sd,
    output logic [WORD_W-1:0] left,
    output logic [WORD_W-1:0] right,
    output logic              left_vld,
    output logic              right_vld
);

    logic [WORD_W-1:0] shreg;
    chan_e             ws_last;
    logic              primed;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '0;
            ws_last   <= CH_RIGHT;
            primed    <= 1'b0;
            left      <= '0;
            right     <= '0;
            left_vld  <= 1'b0;
            right_vld <= 1'b0;
        end else begin
            left_vld  <= 1'b0;
            right_vld <= 1'b0;
            if (rise) begin
                // only the newest WORD_W bits survive: right alignment
                shreg   <= {shreg[WORD_W-2:0], sd};
                primed  <= 1'b1;
                ws_last <= chan_of(ws);
                if (primed && (chan_of(ws) != ws_last)) begin
                    if (ws_last == CH_LEFT) begin
                        left     <= shreg;
                        left_vld <= 1'b1;
                    end else begin
                        right     <= shreg;
                        right_vld <= 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/ap_tx_ser.sv
module ap_tx_ser
    import audio_port_pkg::*;
#(
    parameter int WORD_W = SAMPLE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fall,
    input  logic              ws,
    input  logic              ws_chg,
    input  logic              pd,
    input  logic [WORD_W-1:0] tx_left,
    input  logic [WORD_W-1:0] tx_right,
    output logic              sdout
);

    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

    logic [WORD_W-1:0] shreg, shreg_n, word;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic              bit_q, bit_n;

    always_comb begin
        word    = (chan_of(ws) == CH_LEFT) ? tx_left : tx_right;
        shreg_n = shreg;
        cnt_n   = cnt;
        bit_n   = bit_q;
        if (ws_chg) begin
            bit_n   = word[WORD_W-1];
            shreg_n = {word[WORD_W-2:0], 1'b0};
            cnt_n   = CNT_W'(1);
        end else if (fall) begin
            if (cnt < FULL) begin
                bit_n   = shreg[WORD_W-1];
                shreg_n = {shreg[WORD_W-2:0], 1'b0};
                cnt_n   = cnt + CNT_W'(1);
            end else begin
                bit_n = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            cnt   <= FULL;
            bit_q <= 1'b0;
            sdout <= 1'b0;
        end else begin
            shreg <= shreg_n;
            cnt   <= cnt_n;
            bit_q <= bit_n;
            sdout <= pd ? 1'b0 : bit_n;
        end
    end

endmodule

// File: rtl/serial_audio_port.sv
module serial_audio_port
    import audio_port_pkg::*;
#(
    parameter int WORD_W      = SAMPLE_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bclk,
    input  logic              wclk,
    input  logic              sdin,
    input  logic              adc_pd,
    input  logic [WORD_W-1:0] tx_left,
    input  logic [WORD_W-1:0] tx_right,
    output logic              sdout,
    output logic [WORD_W-1:0] rx_left,
    output logic [WORD_W-1:0] rx_right,
    output logic              rx_left_vld,
    output logic              rx_right_vld
);

    link_ev_t ev;

    ap_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .bclk (bclk),
        .wclk (wclk),
        .sdin (sdin),
        .ev   (ev)
    );

    ap_rx_deser #(.WORD_W(WORD_W)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .rise      (ev.rise),
        .ws        (ev.ws),
        .sd        (ev.sd),
        .left      (rx_left),
        .right     (rx_right),
        .left_vld  (rx_left_vld),
        .right_vld (rx_right_vld)
    );

    ap_tx_ser #(.WORD_W(WORD_W)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .fall     (ev.fall),
        .ws       (ev.ws),
        .ws_chg   (ev.ws_chg),
        .pd       (adc_pd),
        .tx_left  (tx_left),
        .tx_right (tx_right),
        .sdout    (sdout)
    );

endmodule

// File: rtl/ap_checker.sv
module ap_checker #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              adc_pd,
    input logic              sdout,
    input logic [WORD_W-1:0] rx_left,
    input logic [WORD_W-1:0] rx_right,
    input logic              rx_left_vld,
    input logic              rx_right_vld
);

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rx_left_vld, rx_right_vld}));

    // R2
    left_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_left_vld |=> !rx_left_vld);

    // R3
    right_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_right_vld |=> !rx_right_vld);

    // R2
    left_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_left_vld |=> $stable(rx_left) || rx_left_vld);

    // R3
    right_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_right_vld |=> $stable(rx_right) || rx_right_vld);

    // R7
    pd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        adc_pd |=> !sdout);

endmodule

bind serial_audio_port ap_checker #(.WORD_W(WORD_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .adc_pd       (adc_pd),
    .sdout        (sdout),
    .rx_left      (rx_left),
    .rx_right     (rx_right),
    .rx_left_vld  (rx_left_vld),
    .rx_right_vld (rx_right_vld)
);

// File: tb/serial_audio_port_bench.sv
module serial_audio_port_bench;

    localparam int W    = 16;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bclk = 1'b0, wclk = 1'b0, sdin = 1'b0, adc_pd = 1'b0;
    logic [W-1:0] tx_left = '0, tx_right = '0;
    logic sdout, rx_left_vld, rx_right_vld;
    logic [W-1:0] rx_left, rx_right;

    int checks = 0;
    int errors = 0;
    int lcnt = 0;
    int rcnt = 0;
    logic [W-1:0] exp_left = '0, exp_right = '0;
    bit done = 0;
    bit exp_l_ok = 0, exp_r_ok = 0;

    always #2.5 clk = ~clk;

    serial_audio_port u_serial_audio_port (
        .clk(clk), .rst(rst), .bclk(bclk), .wclk(wclk), .sdin(sdin),
        .adc_pd(adc_pd), .tx_left(tx_left), .tx_right(tx_right),
        .sdout(sdout), .rx_left(rx_left), .rx_right(rx_right),
        .rx_left_vld(rx_left_vld), .rx_right_vld(rx_right_vld)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // receive strobe monitor: R1 R2 R3 R4 R9
    logic prev_l = 0, prev_r = 0;
    always @(negedge clk) begin
        if (!rst) begin
            check(!(rx_left_vld && rx_right_vld), "R9 strobes together",
                  {30'd0, rx_left_vld, rx_right_vld}, 32'd0);
            if (prev_l) check(!rx_left_vld, "R2 left strobe width", 32'(rx_left_vld), 32'd0);
            if (prev_r) check(!rx_right_vld, "R3 right strobe width", 32'(rx_right_vld), 32'd0);
            if (rx_left_vld) begin
                lcnt++;
                if (exp_l_ok) check(rx_left == exp_left, "R1 R2 R4 left word", 32'(rx_left), 32'(exp_left));
            end
            if (rx_right_vld) begin
                rcnt++;
                if (exp_r_ok) check(rx_right == exp_right, "R1 R3 R4 right word", 32'(rx_right), 32'(exp_right));
            end
            prev_l = rx_left_vld;
            prev_r = rx_right_vld;
        end
    end

    task automatic slot(input logic ws, input logic d, input logic exp_sd, input string tag);
        wclk = ws;
        sdin = d;
        bclk = 1'b0;
        repeat (HALF) @(negedge clk);
        check(sdout == exp_sd, tag, 32'(sdout), 32'(exp_sd));
        bclk = 1'b1;
        repeat (HALF) @(negedge clk);
        bclk = 1'b0;
    endtask

    // n slots in this half; zero_tx forces expected output low
    task automatic half(input logic ws, input int n, input logic [W-1:0] rxw,
                        input logic [W-1:0] txw, input bit zero_tx);
        for (int k = 0; k < n; k++) begin
            logic d, e;
            d = (k < n - W) ? ~k[0] : rxw[W-1-(k-(n-W))];
            e = (!zero_tx && k < W) ? txw[W-1-k] : 1'b0;
            if (zero_tx)
                slot(ws, d, e, "R7 R8 zero output");
            else if (k < W)
                slot(ws, d, e, $sformatf("R4 R5 data bit n=%0d k=%0d", n, k));
            else
                slot(ws, d, e, $sformatf("R4 R6 pad bit n=%0d k=%0d", n, k));
        end
    endtask

    function automatic logic [W-1:0] pick(input int i, input int salt);
        case (i)
            0: return 16'h8000;
            1: return 16'h0001;
            2: return 16'hFFFF;
            3: return 16'h0000;
            default: return W'((i * 40503 + salt * 977) ^ 16'h5A3C);
        endcase
    endfunction

    task automatic frame(input int n, input logic [W-1:0] lw, input logic [W-1:0] rw, input bit pd);
        logic [W-1:0] tl, tr;
        tl = {lw[7:0], lw[15:8]} ^ 16'h0F0F;
        tr = rw ^ 16'h3C3C;
        tx_left  = tl;
        tx_right = tr;
        adc_pd   = pd;
        half(1'b1, n, lw, tl, pd);
        exp_left = lw;
        exp_l_ok = 1;
        half(1'b0, n, rw, tr, pd);
        exp_right = rw;
        exp_r_ok  = 1;
    endtask

    initial begin
        int nf;
        nf = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8 reset state
        check(sdout == 0, "R8 reset sdout", 32'(sdout), 0);
        check(rx_left == 0 && rx_right == 0, "R8 reset words", {rx_left, rx_right}, 0);
        check(!rx_left_vld && !rx_right_vld, "R8 reset strobes", {rx_left_vld, rx_right_vld}, 0);
        // warm-up right half before any word clock edge
        half(1'b0, 20, 16'hA5C3, 16'h0000, 1);
        check(lcnt == 0 && rcnt == 0, "R8 no early strobe", 32'(lcnt + rcnt), 0);
        exp_right = 16'hA5C3;
        exp_r_ok  = 1;
        // R4 sweep over 32, 48, 64 bit clocks per frame
        for (int fl = 0; fl < 3; fl++) begin
            for (int i = 0; i < 4; i++) begin
                frame(16 + 8 * fl, pick(i + 4 * fl, fl), pick(i + 1 + 4 * fl, fl + 7), 0);
                nf++;
            end
        end
        // R7 power-down frame, receive keeps working
        frame(24, 16'h1234, 16'hFEDC, 1);
        nf++;
        frame(16, 16'h7FFF, 16'h8001, 0);
        nf++;
        // trailing edge to close the final right half
        tx_left = 16'h0000;
        adc_pd  = 0;
        half(1'b1, 16, 16'h0000, 16'h0000, 0);
        repeat (8) @(negedge clk);
        check(lcnt == nf, "R2 left strobe count", 32'(lcnt), 32'(nf));
        check(rcnt == nf + 1, "R3 right strobe count", 32'(rcnt), 32'(nf + 1));
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule